// File: doc/BRIEF.md
# Open-Page DRAM Row-Buffer Controller

This block stands in front of a small bit-wide DRAM model organised as a grid of rows and columns, with one row buffer and an open-page policy. A request arrives on a valid/ready handshake. It carries a read/write flag, a row, a column and a single write bit. If the addressed row is already held in the buffer, the request is a page hit and is served straight from the buffer. If not, the request is a page miss. On a miss the block writes the buffer back into the row it came from, if one is held. It then loads the target row into the buffer and afterwards serves the access.

Sensing a row is destructive. Loading a row into the buffer empties that row in the array, so the only live copy sits in the buffer until it is written back. A refresh timer raises a refresh request at a fixed interval of cycles. A pending refresh wins over new traffic. The refresh first closes any open page. It then loads the row named by a wrapping refresh pointer and writes that row straight back. It leaves no page open. With this scheme every row is rewritten within ROWS refresh intervals, whatever the request traffic is doing.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset `reqReady` is 1, `rdValid` is 0, no page is open and every cell reads back as 0.
- R2: A read returns bit `reqCol` of row `reqRow`. Column index c selects bit c of the row, with bit 0 at column 0.
- R3: A write changes only the addressed bit. Every other bit in the same row and in the other rows keeps its value.
- R4: A page hit is accepted with no busy time. A read hit raises `rdValid` in the cycle right after the accepting edge, and `reqReady` stays 1 in that cycle.
- R5: A page miss, which means no page is open or a different row is open, holds `reqReady` low for MISS_CYCLES cycles after the accepting edge. A read miss delivers its data MISS_CYCLES edges later than a hit would.
- R6: Before a different row is loaded, the open row buffer is written back, so the data of the previously open row survives the switch.
- R7: A refresh falls due every REFRESH_INTERVAL cycles. While it is pending `reqReady` is low. When the block is idle the refresh occupies exactly 3 cycles (close, load, write back). The refresh pointer steps through the rows modulo ROWS.
- R8: A refresh leaves no page open and keeps all data. The next access, even to the previously open row, is a page miss.
- R9: Each read produces exactly one one-cycle `rdValid` pulse. A write produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken on an edge where valid and ready are both 1 |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqRow | input | $clog2(ROWS) | Row address |
| reqCol | input | $clog2(COLS) | Column address |
| reqData | input | 1 | Bit to write |
| rdValid | output | 1 | One-cycle pulse carrying read data |
| rdData | output | 1 | Read result, valid while rdValid is 1 |

## Verification
A read hit's `rdValid` is due in the first cycle after the accepting edge. A read miss's `rdValid` is due MISS_CYCLES cycles later, and `reqReady` returns high in that same cycle. The bench samples on the falling edge and counts samples from the accepting edge. It then compares the count of low-`reqReady` samples with MISS_CYCLES for a miss and with 0 for a hit. Any extra low samples must come in whole groups of 3, which marks a refresh. The bench then records the page as closed in its model, so the next access is expected to be a miss.

// File: rtl/dram_page_ctrl_pkg.sv
package dram_page_ctrl_pkg;

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_MISS     = 2'd1,
    S_REF_OPEN = 2'd2,
    S_REF_WB   = 2'd3
  } ctlState_e;

  // strobes from control to datapath; addresses travel beside the struct
  typedef struct packed {
    logic wbEn;      // copy row buffer into array row wbRow
    logic ldEn;      // copy array row ldRow into buffer, clear that row
    logic accEn;     // access one buffer bit at accCol
    logic accWrite;  // access is a write
    logic accData;   // bit to write
  } dpStrobe_t;

endpackage

// File: rtl/dram_page_ctrl_ctl.sv
module dram_page_ctrl_ctl
  import dram_page_ctrl_pkg::*;
#(
  parameter int ROWS             = 4,
  parameter int COLS             = 4,
  parameter int MISS_CYCLES      = 3,
  parameter int REFRESH_INTERVAL = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [$clog2(ROWS)-1:0] reqRow,
  input  logic [$clog2(COLS)-1:0] reqCol,
  input  logic                    reqData,
  output dpStrobe_t               stb,
  output logic [$clog2(ROWS)-1:0] wbRow,
  output logic [$clog2(ROWS)-1:0] ldRow,
  output logic [$clog2(COLS)-1:0] accCol,
  output ctlState_e               stateOut,
  output logic                    refPendingOut,
  output logic                    refTickOut,
  output logic                    refDoneOut,
  output logic [$clog2(ROWS)-1:0] refRowOut
);

  localparam int RW  = $clog2(ROWS);
  localparam int CW  = $clog2(COLS);
  localparam int TW  = $clog2(REFRESH_INTERVAL);
  localparam int MCW = $clog2(MISS_CYCLES);
  localparam logic [TW-1:0]  TIMER_LAST = TW'(REFRESH_INTERVAL - 1);
  localparam logic [MCW-1:0] MISS_LAST  = MCW'(MISS_CYCLES - 1);
  localparam logic [RW-1:0]  ROW_LAST   = RW'(ROWS - 1);

  ctlState_e        state, nextState;
  logic [TW-1:0]    refTimer;
  logic             refPending;
  logic [RW-1:0]    refRow;
  logic             pageOpen;
  logic [RW-1:0]    openRow;
  logic [MCW-1:0]   missCnt;
  logic             lWrite;
  logic [RW-1:0]    lRow;
  logic [CW-1:0]    lCol;
  logic             lData;
  logic             refTick;
  logic             refDone;
  logic             missStart;
  logic             pageHit;

  assign refTick  = (refTimer == TIMER_LAST);
  assign pageHit  = pageOpen && (reqRow == openRow);
  assign reqReady = (state == S_IDLE) && !refPending;

  always_comb begin
    stb       = '0;
    wbRow     = openRow;
    ldRow     = lRow;
    accCol    = reqCol;
    nextState = state;
    refDone   = 1'b0;
    missStart = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (refPending) begin
          stb.wbEn  = pageOpen;
          wbRow     = openRow;
          nextState = S_REF_OPEN;
        end else if (reqValid) begin
          if (pageHit) begin
            stb.accEn    = 1'b1;
            stb.accWrite = reqWrite;
            stb.accData  = reqData;
            accCol       = reqCol;
          end else begin
            missStart = 1'b1;
            nextState = S_MISS;
          end
        end
      end
      S_MISS: begin
        if (missCnt == '0) begin
          stb.wbEn = pageOpen;
          wbRow    = openRow;
        end
        if (missCnt == MCW'(1)) begin
          stb.ldEn = 1'b1;
          ldRow    = lRow;
        end
        if (missCnt == MISS_LAST) begin
          stb.accEn    = 1'b1;
          stb.accWrite = lWrite;
          stb.accData  = lData;
          accCol       = lCol;
          nextState    = S_IDLE;
        end
      end
      S_REF_OPEN: begin
        stb.ldEn  = 1'b1;
        ldRow     = refRow;
        nextState = S_REF_WB;
      end
      S_REF_WB: begin
        stb.wbEn  = 1'b1;
        wbRow     = refRow;
        refDone   = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nextState;
    end
  end

  // refresh timer and pending flag; a new tick wins over a completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      refTimer <= refTick ? '0 : refTimer + TW'(1);
      if (refTick) begin
        refPending <= 1'b1;
      end else if (refDone) begin
        refPending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refRow <= '0;
    end else if (refDone) begin
      refRow <= (refRow == ROW_LAST) ? '0 : refRow + RW'(1);
    end
  end

  // open-page bookkeeping follows the close and load strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageOpen <= 1'b0;
      openRow  <= '0;
    end else if (stb.wbEn) begin
      pageOpen <= 1'b0;
    end else if (stb.ldEn && state == S_MISS) begin
      pageOpen <= 1'b1;
      openRow  <= lRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt <= '0;
      lWrite  <= 1'b0;
      lRow    <= '0;
      lCol    <= '0;
      lData   <= 1'b0;
    end else if (missStart) begin
      missCnt <= '0;
      lWrite  <= reqWrite;
      lRow    <= reqRow;
      lCol    <= reqCol;
      lData   <= reqData;
    end else if (state == S_MISS) begin
      missCnt <= missCnt + MCW'(1);
    end
  end

  assign stateOut      = state;
  assign refPendingOut = refPending;
  assign refTickOut    = refTick;
  assign refDoneOut    = refDone;
  assign refRowOut     = refRow;

endmodule

// File: rtl/dram_page_ctrl_dp.sv
module dram_page_ctrl_dp
  import dram_page_ctrl_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic [$clog2(ROWS)-1:0] wbRow,
  input  logic [$clog2(ROWS)-1:0] ldRow,
  input  logic [$clog2(COLS)-1:0] accCol,
  output logic                    rdValid,
  output logic                    rdData
);

  logic [COLS-1:0] cellArr [ROWS];
  logic [COLS-1:0] rowBuf;
  logic [ROWS-1:0] wbSel;
  logic [ROWS-1:0] ldSel;

  // per-row decode of write-back and destructive-load targets
  for (genvar r = 0; r < ROWS; r++) begin : g_rowSel
    assign wbSel[r] = stb.wbEn && (wbRow == $clog2(ROWS)'(r));
    assign ldSel[r] = stb.ldEn && (ldRow == $clog2(ROWS)'(r));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        cellArr[r] <= '0;
      end
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (wbSel[r]) begin
          cellArr[r] <= rowBuf;
        end else if (ldSel[r]) begin
          cellArr[r] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBuf <= '0;
    end else if (stb.ldEn) begin
      rowBuf <= cellArr[ldRow];
    end else if (stb.accEn && stb.accWrite) begin
      rowBuf[accCol] <= stb.accData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 1'b0;
    end else begin
      rdValid <= stb.accEn && !stb.accWrite;
      rdData  <= (stb.accEn && !stb.accWrite) ? rowBuf[accCol] : 1'b0;
    end
  end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_ctrl_pkg::*;
#(
  parameter int ROWS             = 4,
  parameter int COLS             = 4,
  parameter int MISS_CYCLES      = 3,
  parameter int REFRESH_INTERVAL = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [$clog2(ROWS)-1:0] reqRow,
  input  logic [$clog2(COLS)-1:0] reqCol,
  input  logic                    reqData,
  output logic                    rdValid,
  output logic                    rdData
);

  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  dpStrobe_t  stb;
  logic [RW-1:0] wbRow;
  logic [RW-1:0] ldRow;
  logic [CW-1:0] accCol;
  ctlState_e  ctlState;
  logic       refPending;
  logic       refTick;
  logic       refDone;
  logic [RW-1:0] refRow;

  dram_page_ctrl_ctl #(
    .ROWS(ROWS), .COLS(COLS),
    .MISS_CYCLES(MISS_CYCLES), .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .stb(stb), .wbRow(wbRow), .ldRow(ldRow), .accCol(accCol),
    .stateOut(ctlState), .refPendingOut(refPending), .refTickOut(refTick),
    .refDoneOut(refDone), .refRowOut(refRow)
  );

  dram_page_ctrl_dp #(
    .ROWS(ROWS), .COLS(COLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wbRow(wbRow), .ldRow(ldRow), .accCol(accCol),
    .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk
  import dram_page_ctrl_pkg::*;
#(
  parameter int ROWS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic                    reqWrite,
  input logic                    rdValid,
  input ctlState_e               ctlState,
  input logic                    refPending,
  input logic                    refTick,
  input logic                    refDone,
  input logic [$clog2(ROWS)-1:0] refRow
);

  localparam logic [$clog2(ROWS)-1:0] ROW_LAST = $clog2(ROWS)'(ROWS - 1);

  AST_REFRESH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    refPending |-> !reqReady);  // R7

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> ctlState == S_IDLE);  // R5

  AST_NO_MISSED_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> !refPending);  // R7

  AST_REFROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> refRow == (($past(refRow) == ROW_LAST) ? '0 : $past(refRow) + 1'b1));  // R7

  AST_RDVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(ctlState) == S_MISS) ||
                $past(reqValid && reqReady && !reqWrite));  // R9

  AST_REFRESH_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> ctlState == S_IDLE);  // R8

endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .rdValid(rdValid), .ctlState(ctlState),
  .refPending(refPending), .refTick(refTick), .refDone(refDone),
  .refRow(refRow)
);

// File: tb/dram_page_ctrl_bench.sv
`timescale 1ns/1ps
module dram_page_ctrl_bench;

  localparam int ROWS     = 4;
  localparam int COLS     = 4;
  localparam int MISS     = 3;
  localparam int INTERVAL = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [1:0] reqRow = '0;
  logic [1:0] reqCol = '0;
  logic reqData = 1'b0;
  logic rdValid;
  logic rdData;

  int total = 0;
  int fails = 0;
  int refreshes = 0;
  int cycleCnt = 0;
  logic model [ROWS][COLS];
  bit modelOpen = 0;
  int modelRow = 0;
  bit refClosed = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rstN) cycleCnt++;

  dram_page_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .MISS_CYCLES(MISS), .REFRESH_INTERVAL(INTERVAL)
  ) u_dram_page_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request; starts and ends on a falling edge with reqReady high
  task automatic doOp(input bit wr, input int row, input int col, input bit d,
                      input string tag);
    int pre = 0;
    int s = 1;
    int low = 0;
    int lat = 0;
    int pulses = 0;
    int base;
    int extra;
    bit got = 0;
    bit miss;
    while (!reqReady) begin
      pre++;
      @(negedge clk);
    end
    if (pre > 0) begin
      check(pre % 3 == 0, "R7 refresh length", pre, 3);
      refreshes += pre / 3;
      modelOpen = 0;
      refClosed = 1;
    end
    miss = !(modelOpen && modelRow == row);
    reqValid = 1'b1;
    reqWrite = wr;
    reqRow   = 2'(row);
    reqCol   = 2'(col);
    reqData  = d;
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      if (rdValid) begin
        pulses++;
        lat = s;
        got = rdData;
      end
      if (reqReady) break;
      low++;
      @(negedge clk);
      s++;
    end
    base  = miss ? MISS : 0;
    extra = low - base;
    check(extra >= 0 && extra % 3 == 0, "R7 busy length", low, base);
    if (extra > 0) refreshes += extra / 3;
    if (!wr) begin
      check(pulses == 1, "R9 read pulse count", pulses, 1);
      if (miss)
        check(lat == base + 1, refClosed ? "R8 miss after refresh latency" : "R5 miss latency",
              lat, base + 1);
      else
        check(lat == 1, "R4 hit latency", lat, 1);
      check(got == model[row][col], tag, int'(got), int'(model[row][col]));
    end else begin
      check(pulses == 0, "R9 no pulse on write", pulses, 0);
      model[row][col] = d;
    end
    if (miss) refClosed = 0;
    modelOpen = 1;
    modelRow  = row;
    if (extra > 0) begin
      modelOpen = 0;
      refClosed = 1;
    end
  endtask

  task automatic waitRefresh();
    int low = 0;
    while (reqReady) @(negedge clk);
    while (!reqReady) begin
      low++;
      @(negedge clk);
    end
    check(low == 3, "R7 idle refresh length", low, 3);
    refreshes++;
    modelOpen = 0;
    refClosed = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycleCnt);
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) model[r][c] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    check(rdValid == 1'b0, "R1 rdValid after reset", int'(rdValid), 0);

    // R1: everything reads zero
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) doOp(0, r, c, 0, "R1 zero after reset");

    // pattern (r ^ c) & 1 ^ (r == 3), row-major: hits after each row opens
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) doOp(1, r, c, bit'(((r ^ c) & 1) ^ (r == 3)), "R3");

    // column-major reads switch rows every access: R6 write-back
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) doOp(0, r, c, 0, "R6 data after row switch");

    // R3: flip one bit then read its row and a neighbour row
    doOp(1, 1, 2, ~model[1][2], "R3");
    for (int c = 0; c < COLS; c++) doOp(0, 1, c, 0, "R3 row after single-bit write");
    for (int c = 0; c < COLS; c++) doOp(0, 2, c, 0, "R3 neighbour row untouched");

    // R8: open a page, let a refresh pass, access the same row
    doOp(0, 2, 0, 0, "R2 read");
    waitRefresh();
    doOp(0, 2, 1, 0, "R8 data kept over refresh");

    // mixed traffic driven by an LFSR
    for (int i = 0; i < 400; i++) begin
      int row;
      int col;
      bit wr;
      bit d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      row = (lfsr[3]) ? int'(lfsr[1:0]) : modelRow;
      col = int'(lfsr[5:4]);
      wr  = lfsr[7];
      d   = lfsr[9];
      doOp(wr, row, col, d, "R2 read data");
    end

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) doOp(0, r, c, 0, "R6 final array");

    check(refreshes >= cycleCnt / INTERVAL - 1, "R7 refresh count", refreshes,
          cycleCnt / INTERVAL - 1);
    summary();
    $finish;
  end

endmodule